// File: doc/BRIEF.md
# Post-Package Repair Sequencer

This block runs one row-repair job inside a memory controller. A host hands it a bank and row address and the kind of repair. The block then takes the bank out of normal service. It drives the repair actions in a fixed order and proves the repair with a hardware pattern check before giving the bank back. A soft repair loads the failing address straight into the remapper's comparator shadow registers. A hard repair drives a timed fuse-programming pulse, then holds an internal reset so the repair table reloads with the new address map.

Once the repair action is complete, the block writes a test word derived from the repaired address to that row and reads it back, then compares all bits. The repair-valid flag is set only when every bit matches. A mismatch, a missing read response, or a hard repair attempted outside the allowed temperature ends the job with an error code, and repair-valid stays clear. Separate counters record successful hard and soft repairs so the host can read them.

Top module: `repair_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle; a request is taken at a clock edge where `req_valid` and `req_ready` are both high. A request presented while a job runs (including its completion cycle) is held off and is taken at the first edge after the sequencer is idle again.
- R2: From the cycle after acceptance up to the cycle before `done`, `repair_mode` is high and `freeze_mask` has exactly the bit of the accepted bank set (bit index = bank number). In the `done` cycle and while idle both are low. Every fuse, reload, remap and memory action happens while that freeze is set.
- R3: `prog_bank`/`prog_row` and `mem_bank`/`mem_row` carry the accepted address and stay unchanged for the whole job, whatever the request inputs do meanwhile.
- R4: A soft job (`req_hard`=0) gives exactly one `remap_load` cycle, in the cycle after the entry cycle, and no fuse pulse or reload, whatever `temp_ok` is.
- R5: A hard job with `temp_ok` high at the end of the entry cycle drives `fuse_pulse` for exactly PULSE_W consecutive cycles, then `table_reload` for exactly RST_HOLD consecutive cycles, and only then starts verification.
- R6: A hard job with `temp_ok` low at the end of the entry cycle drives no fuse pulse, no reload and no memory access. It ends at once with `err_code` 1.
- R7: Verification issues one `mem_wr` cycle and, in the following cycle, one `mem_rd` cycle to the job address. Write-data bit i equals bit (i mod K) of the key {bank,row} (K = bank width + row width), inverted when i is odd.
- R8: Read data is taken in any of the WAIT_MAX cycles after the read cycle, including the last one. If no `mem_rvalid` arrives in that window, the job ends with `err_code` 3.
- R9: If the returned word equals the written word in every bit, the job ends with `done_ok`=1, `err_code` 0 and `repair_valid` set. If any bit differs, it ends with `err_code` 2, `done_ok`=0 and `repair_valid` clear.
- R10: `repair_valid` holds its value after a job ends and is cleared when the next request is accepted.
- R11: `hard_count`/`soft_count` rise by one in the `done` cycle of each successful hard/soft job and never change otherwise.
- R12: `done` is a one-cycle pulse ending each job; `err_code` is 0 none, 1 temperature, 2 compare mismatch, 3 read timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Repair request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_hard | input | 1 | 1 = hard (fuse) repair, 0 = soft repair |
| req_bank | input | BANK_W | Bank of the failing row |
| req_row | input | ROW_W | Failing row address |
| temp_ok | input | 1 | Device temperature inside the fuse-programming range |
| repair_mode | output | 1 | Repair mode entered |
| freeze_mask | output | NUM_BANKS | One-hot traffic freeze per bank |
| prog_bank | output | BANK_W | Bank being repaired |
| prog_row | output | ROW_W | Row being repaired |
| remap_load | output | 1 | Load the address into the comparator shadow registers |
| fuse_pulse | output | 1 | Fuse-programming pulse |
| table_reload | output | 1 | Internal reset / repair-table reload |
| mem_wr | output | 1 | Verification write strobe |
| mem_rd | output | 1 | Verification read strobe |
| mem_bank | output | BANK_W | Verification access bank |
| mem_row | output | ROW_W | Verification access row |
| mem_wdata | output | DATA_W | Verification test word |
| mem_rdata | input | DATA_W | Read-back data |
| mem_rvalid | input | 1 | Read-back data valid |
| done | output | 1 | Job finished (one cycle) |
| done_ok | output | 1 | Job finished successfully |
| err_code | output | 2 | Result code of the last job |
| repair_valid | output | 1 | Last repair verified |
| hard_count | output | CNT_W | Successful hard repairs |
| soft_count | output | CNT_W | Successful soft repairs |

## Verification
Two pairs of events can fall in the same cycle. The read response can arrive in the last cycle of the wait window, the same cycle in which the timeout would fire. A vector returns data exactly WAIT_MAX cycles after the read strobe and must end in success, while one cycle later must end in a timeout. A new request can also be pending in the completion cycle of the running job. The bench keeps `req_valid` high with a second address through the whole first job and checks that `req_ready` stays low in the `done` cycle, rises in the following idle cycle, and that the second address appears on `prog_bank`/`prog_row` only after that.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

  typedef enum logic [3:0] {
    S_IDLE   = 4'd0,
    S_ENTER  = 4'd1,
    S_SOFT   = 4'd2,
    S_BLOW   = 4'd3,
    S_RELOAD = 4'd4,
    S_VWR    = 4'd5,
    S_VRD    = 4'd6,
    S_VWAIT  = 4'd7,
    S_PASS   = 4'd8,
    S_FAIL   = 4'd9
  } rpr_state_e;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_TEMP     = 2'd1,
    ERR_MISMATCH = 2'd2,
    ERR_TIMEOUT  = 2'd3
  } rpr_err_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rpr_timer.sv
module rpr_timer #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         last
);

  logic [W-1:0] cnt;

  // Holds len-1 in the first cycle of a state; last marks the final cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len - W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign last = (cnt == '0);

endmodule

// File: rtl/rpr_freeze_dec.sv
module rpr_freeze_dec #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BANK_W    = 3
) (
  input  logic                 en,
  input  logic [BANK_W-1:0]    bank,
  output logic [NUM_BANKS-1:0] mask
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign mask[b] = en && (bank == BANK_W'(b));
  end

endmodule

// File: rtl/rpr_verify.sv
module rpr_verify #(
  parameter int unsigned BANK_W = 3,
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] wdata,
  output logic              match
);

  localparam int unsigned KEY_W = BANK_W + ROW_W;

  // Address-derived word: key bits repeated, odd positions inverted.
  function automatic logic [DATA_W-1:0] make_pattern(input logic [KEY_W-1:0] key);
    logic [DATA_W-1:0] p;
    for (int i = 0; i < DATA_W; i++) begin
      p[i] = key[i % KEY_W] ^ i[0];
    end
    return p;
  endfunction

  assign wdata = make_pattern({bank, row});
  assign match = (rdata == wdata);

endmodule

// File: rtl/rpr_act_cnt.sv
module rpr_act_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (inc) begin
      count <= count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/repair_seq.sv
module repair_seq #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ROW_W     = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PULSE_W   = 6,
  parameter int unsigned RST_HOLD  = 3,
  parameter int unsigned WAIT_MAX  = 4,
  parameter int unsigned CNT_W     = 8,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_hard,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [ROW_W-1:0]     req_row,
  input  logic                 temp_ok,
  output logic                 repair_mode,
  output logic [NUM_BANKS-1:0] freeze_mask,
  output logic [BANK_W-1:0]    prog_bank,
  output logic [ROW_W-1:0]     prog_row,
  output logic                 remap_load,
  output logic                 fuse_pulse,
  output logic                 table_reload,
  output logic                 mem_wr,
  output logic                 mem_rd,
  output logic [BANK_W-1:0]    mem_bank,
  output logic [ROW_W-1:0]     mem_row,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  input  logic                 mem_rvalid,
  output logic                 done,
  output logic                 done_ok,
  output logic [1:0]           err_code,
  output logic                 repair_valid,
  output logic [CNT_W-1:0]     hard_count,
  output logic [CNT_W-1:0]     soft_count
);
  import rpr_pkg::*;

  localparam int unsigned MAXLEN = max3(PULSE_W, RST_HOLD, WAIT_MAX);
  localparam int unsigned TMR_W  = $clog2(MAXLEN + 1);

  rpr_state_e        state, state_nxt;
  rpr_err_e          err_q;
  logic [BANK_W-1:0] job_bank;
  logic [ROW_W-1:0]  job_row;
  logic              job_hard;

  // Named internal events
  logic              accept;
  logic              temp_block;
  logic              pass_evt;
  logic              mismatch_evt;
  logic              timeout_evt;
  logic              busy_win;
  logic              tmr_load;
  logic              tmr_last;
  logic [TMR_W-1:0]  tmr_len;
  logic              cmp_match;

  assign accept       = req_valid && req_ready;
  assign temp_block   = (state == S_ENTER) && job_hard && !temp_ok;
  assign pass_evt     = (state == S_VWAIT) && mem_rvalid && cmp_match;
  assign mismatch_evt = (state == S_VWAIT) && mem_rvalid && !cmp_match;
  assign timeout_evt  = (state == S_VWAIT) && !mem_rvalid && tmr_last;

  // Job capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      job_bank <= '0;
      job_row  <= '0;
      job_hard <= 1'b0;
    end else if (accept) begin
      job_bank <= req_bank;
      job_row  <= req_row;
      job_hard <= req_hard;
    end
  end

  // Sequencer
  always_comb begin
    state_nxt = state;
    unique case (state)
      S_IDLE:   if (req_valid) state_nxt = S_ENTER;
      S_ENTER: begin
        if (!job_hard)    state_nxt = S_SOFT;
        else if (temp_ok) state_nxt = S_BLOW;
        else              state_nxt = S_FAIL;
      end
      S_SOFT:   state_nxt = S_VWR;
      S_BLOW:   if (tmr_last) state_nxt = S_RELOAD;
      S_RELOAD: if (tmr_last) state_nxt = S_VWR;
      S_VWR:    state_nxt = S_VRD;
      S_VRD:    state_nxt = S_VWAIT;
      S_VWAIT: begin
        if (pass_evt)                         state_nxt = S_PASS;
        else if (mismatch_evt || timeout_evt) state_nxt = S_FAIL;
      end
      S_PASS:   state_nxt = S_IDLE;
      S_FAIL:   state_nxt = S_IDLE;
      default:  state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nxt;
  end

  // Result code and verified flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q        <= ERR_NONE;
      repair_valid <= 1'b0;
    end else begin
      if (accept) begin
        err_q        <= ERR_NONE;
        repair_valid <= 1'b0;
      end
      if (temp_block)   err_q <= ERR_TEMP;
      if (mismatch_evt) err_q <= ERR_MISMATCH;
      if (timeout_evt)  err_q <= ERR_TIMEOUT;
      if (pass_evt)     repair_valid <= 1'b1;
    end
  end

  // Phase timer: length chosen by the state being entered
  always_comb begin
    unique case (state_nxt)
      S_BLOW:   tmr_len = TMR_W'(PULSE_W);
      S_RELOAD: tmr_len = TMR_W'(RST_HOLD);
      S_VWAIT:  tmr_len = TMR_W'(WAIT_MAX);
      default:  tmr_len = TMR_W'(1);
    endcase
  end
  assign tmr_load = (state_nxt != state);

  rpr_timer #(.W(TMR_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .len   (tmr_len),
    .last  (tmr_last)
  );

  // Freeze window and bank decode
  assign busy_win = (state != S_IDLE) && (state != S_PASS) && (state != S_FAIL);

  rpr_freeze_dec #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_freeze (
    .en   (busy_win),
    .bank (job_bank),
    .mask (freeze_mask)
  );

  rpr_verify #(.BANK_W(BANK_W), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_verify (
    .bank  (job_bank),
    .row   (job_row),
    .rdata (mem_rdata),
    .wdata (mem_wdata),
    .match (cmp_match)
  );

  rpr_act_cnt #(.CNT_W(CNT_W)) u_hard_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (pass_evt && job_hard),
    .count (hard_count)
  );

  rpr_act_cnt #(.CNT_W(CNT_W)) u_soft_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (pass_evt && !job_hard),
    .count (soft_count)
  );

  // Port drive
  assign req_ready    = (state == S_IDLE);
  assign repair_mode  = busy_win;
  assign prog_bank    = job_bank;
  assign prog_row     = job_row;
  assign mem_bank     = job_bank;
  assign mem_row      = job_row;
  assign remap_load   = (state == S_SOFT);
  assign fuse_pulse   = (state == S_BLOW);
  assign table_reload = (state == S_RELOAD);
  assign mem_wr       = (state == S_VWR);
  assign mem_rd       = (state == S_VRD);
  assign done         = (state == S_PASS) || (state == S_FAIL);
  assign done_ok      = (state == S_PASS);
  assign err_code     = err_q;

  // Assertions
  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!repair_mode && !done));

  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (repair_mode && !req_ready));

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(freeze_mask));

  a_r2_freeze_mode: assert property (@(posedge clk) disable iff (!rst_n)
    repair_mode |-> ($countones(freeze_mask) == 1));

  a_r2_actions_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_pulse || table_reload || remap_load || mem_wr || mem_rd) |-> repair_mode);

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    repair_mode |=> (!repair_mode || ($stable(prog_bank) && $stable(prog_row))));

  a_r4_soft_no_fuse: assert property (@(posedge clk) disable iff (!rst_n)
    remap_load |-> (!job_hard && !fuse_pulse));

  a_r5_fuse_hard: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_pulse |-> (job_hard && repair_mode));

  a_r6_temp_block: assert property (@(posedge clk) disable iff (!rst_n)
    temp_block |=> (done && !done_ok && (err_code == 2'd1)));

  a_r7_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> mem_rd);

  a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(repair_valid) |-> done_ok);

  a_r11_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_evt |=> ($stable(hard_count) && $stable(soft_count)));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/tb_repair_seq.sv
module tb_repair_seq;

  localparam int NUM_BANKS = 8;
  localparam int BANK_W    = 3;
  localparam int ROW_W     = 12;
  localparam int DATA_W    = 32;
  localparam int PULSE_W   = 6;
  localparam int RST_HOLD  = 3;
  localparam int WAIT_MAX  = 4;
  localparam int CNT_W     = 8;

  logic                 clk, rst_n;
  logic                 req_valid, req_ready, req_hard, temp_ok;
  logic [BANK_W-1:0]    req_bank, prog_bank, mem_bank;
  logic [ROW_W-1:0]     req_row, prog_row, mem_row;
  logic                 repair_mode, remap_load, fuse_pulse, table_reload;
  logic [NUM_BANKS-1:0] freeze_mask;
  logic                 mem_wr, mem_rd, mem_rvalid;
  logic [DATA_W-1:0]    mem_wdata, mem_rdata;
  logic                 done, done_ok, repair_valid;
  logic [1:0]           err_code;
  logic [CNT_W-1:0]     hard_count, soft_count;

  repair_seq #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .DATA_W(DATA_W), .PULSE_W(PULSE_W),
    .RST_HOLD(RST_HOLD), .WAIT_MAX(WAIT_MAX), .CNT_W(CNT_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_hard(req_hard), .req_bank(req_bank), .req_row(req_row), .temp_ok(temp_ok),
    .repair_mode(repair_mode), .freeze_mask(freeze_mask), .prog_bank(prog_bank),
    .prog_row(prog_row), .remap_load(remap_load), .fuse_pulse(fuse_pulse),
    .table_reload(table_reload), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_bank(mem_bank), .mem_row(mem_row), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .done(done), .done_ok(done_ok),
    .err_code(err_code), .repair_valid(repair_valid), .hard_count(hard_count),
    .soft_count(soft_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int hard_exp = 0;
  int soft_exp = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Test word: key {bank,row} repeated from bit 0 upward, odd bits inverted
  function automatic logic [31:0] exp_pat(input logic [2:0] b, input logic [11:0] r);
    logic [44:0] rep;
    rep = {3{b, r}};
    return rep[31:0] ^ 32'hAAAA_AAAA;
  endfunction

  // Stimulus/expectation vectors:
  // {hard, temp, bank[3], row[12], resp_delay[3], flip[2], exp_err[2]}
  // flip: 0 none, 1 bit 0, 2 bit 31, 3 both
  localparam logic [23:0] VEC [8] = '{
    {1'b0, 1'b1, 3'd2, 12'h123, 3'd1, 2'd0, 2'd0},
    {1'b1, 1'b1, 3'd5, 12'hABC, 3'd2, 2'd0, 2'd0},
    {1'b1, 1'b0, 3'd1, 12'h005, 3'd1, 2'd0, 2'd1},
    {1'b0, 1'b0, 3'd7, 12'hFFF, 3'd1, 2'd0, 2'd0},
    {1'b0, 1'b1, 3'd0, 12'h000, 3'd1, 2'd1, 2'd2},
    {1'b1, 1'b1, 3'd3, 12'h800, 3'd4, 2'd0, 2'd0},
    {1'b0, 1'b1, 3'd4, 12'h007, 3'd5, 2'd0, 2'd3},
    {1'b1, 1'b1, 3'd6, 12'h555, 3'd1, 2'd2, 2'd2}
  };

  // Monitor / memory responder state
  int          fuse_n, reload_n, remap_n, wr_n, rd_n;
  logic [31:0] wcap;
  logic [2:0]  wbank;
  logic [11:0] wrow;
  bit          viol;
  int          cur_delay;
  logic [1:0]  cur_flip;
  logic [2:0]  cur_bank;
  bit          rd_arm;
  int          rd_age;

  task automatic clear_mon();
    fuse_n = 0; reload_n = 0; remap_n = 0; wr_n = 0; rd_n = 0;
    viol = 0; rd_arm = 0; rd_age = 0; wcap = '0; wbank = '0; wrow = '0;
  endtask

  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    clear_mon();
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (fuse_pulse)   fuse_n++;
        if (table_reload) reload_n++;
        if (remap_load)   remap_n++;
        if ((fuse_pulse || table_reload || remap_load || mem_wr || mem_rd) &&
            (freeze_mask != (8'd1 << cur_bank)))
          viol = 1;
        if (mem_wr) begin
          wr_n++; wcap = mem_wdata; wbank = mem_bank; wrow = mem_row;
        end
        mem_rvalid = 1'b0;
        if (rd_arm) begin
          rd_age++;
          if (rd_age == cur_delay) begin
            mem_rvalid = 1'b1;
            mem_rdata  = wcap ^ {cur_flip[1], 30'd0, cur_flip[0]};
            rd_arm     = 0;
          end
        end
        if (mem_rd) begin
          rd_n++; rd_arm = 1; rd_age = 0;
        end
      end
    end
  end

  task automatic wait_done(input string tag);
    int k = 0;
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
    end
    check(done == 1'b1, {tag, " R12 done reached"}, done, 1);
  endtask

  task automatic run_req(input bit hard, input bit temp, input logic [2:0] bank,
                         input logic [11:0] row, input int dly, input logic [1:0] flip,
                         input logic [1:0] exp_err, input string tag);
    bit exp_ok, blow, access;
    exp_ok = (exp_err == 2'd0);
    blow   = hard && temp;
    access = !(hard && !temp);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    clear_mon();
    cur_bank = bank; cur_delay = dly; cur_flip = flip;
    req_valid = 1'b1; req_hard = hard; req_bank = bank; req_row = row; temp_ok = temp;
    @(negedge clk);
    req_valid = 1'b0;
    check(repair_mode && freeze_mask == (8'd1 << bank), {tag, " R2 freeze set"},
          freeze_mask, 8'd1 << bank);
    check(!repair_valid, {tag, " R10 valid cleared on accept"}, repair_valid, 0);
    check(!req_ready, {tag, " R1 ready low when busy"}, req_ready, 0);
    wait_done(tag);
    check(done_ok == exp_ok, {tag, " R9 done_ok"}, done_ok, exp_ok);
    check(err_code == exp_err, {tag, " R12 err_code"}, err_code, exp_err);
    check(repair_valid == exp_ok, {tag, " R9 repair_valid"}, repair_valid, exp_ok);
    check(freeze_mask == '0 && !repair_mode, {tag, " R2 released at done"}, freeze_mask, 0);
    check(prog_bank == bank && prog_row == row && mem_bank == bank && mem_row == row,
          {tag, " R3 address held"}, {prog_bank, prog_row}, {bank, row});
    if (exp_ok) begin
      if (hard) hard_exp++;
      else      soft_exp++;
    end
    check(hard_count == hard_exp[7:0], {tag, " R11 hard_count"}, hard_count, hard_exp);
    check(soft_count == soft_exp[7:0], {tag, " R11 soft_count"}, soft_count, soft_exp);
    check(fuse_n == (blow ? PULSE_W : 0), {tag, " R5 R6 fuse cycles"}, fuse_n,
          blow ? PULSE_W : 0);
    check(reload_n == (blow ? RST_HOLD : 0), {tag, " R5 R6 reload cycles"}, reload_n,
          blow ? RST_HOLD : 0);
    check(remap_n == (hard ? 0 : 1), {tag, " R4 remap loads"}, remap_n, hard ? 0 : 1);
    check(wr_n == (access ? 1 : 0) && rd_n == (access ? 1 : 0),
          {tag, " R6 R7 memory accesses"}, wr_n * 16 + rd_n, access ? 17 : 0);
    if (access) begin
      check(wcap == exp_pat(bank, row), {tag, " R7 test word"}, wcap, exp_pat(bank, row));
      check(wbank == bank && wrow == row, {tag, " R7 access address"},
            {wbank, wrow}, {bank, row});
    end
    check(!viol, {tag, " R2 action outside freeze"}, viol, 0);
    @(negedge clk);
    check(!done, {tag, " R12 done one cycle"}, done, 0);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_hard = 1'b0; req_bank = '0; req_row = '0;
    temp_ok = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    check(req_ready, "R1 ready after reset", req_ready, 1);
    check(freeze_mask == '0 && !repair_mode, "R2 no freeze after reset", freeze_mask, 0);
    check(!done && err_code == 2'd0, "R12 idle after reset", {done, err_code}, 0);
    check(!repair_valid, "R9 valid clear after reset", repair_valid, 0);
    check(hard_count == 0 && soft_count == 0, "R11 counters zero", {hard_count, soft_count}, 0);
    check(!fuse_pulse && !table_reload && !remap_load && !mem_wr && !mem_rd,
          "R5 no actions after reset", fuse_pulse, 0);

    // Vector table (entry 5: response in last window cycle, R8; entry 6: one late, R8)
    for (int v = 0; v < 8; v++) begin
      logic [23:0] e;
      e = VEC[v];
      run_req(e[23], e[22], e[21:19], e[18:7], int'(e[6:4]), e[3:2], e[1:0],
              $sformatf("vec%0d", v));
    end

    // R10: verified flag holds after a successful job
    run_req(1'b0, 1'b1, 3'd3, 12'h0F0, 1, 2'd0, 2'd0, "hold");
    repeat (5) @(negedge clk);
    check(repair_valid, "R10 valid held while idle", repair_valid, 1);

    // R1: second request pending through the first job and its done cycle
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    clear_mon();
    cur_bank = 3'd1; cur_delay = 1; cur_flip = 2'd0;
    req_valid = 1'b1; req_hard = 1'b0; req_bank = 3'd1; req_row = 12'h00A; temp_ok = 1'b1;
    @(negedge clk);
    req_hard = 1'b1; req_bank = 3'd6; req_row = 12'h321;
    begin
      int k = 0;
      while (!done && k < 100) begin
        check(!req_ready && prog_bank == 3'd1 && prog_row == 12'h00A,
              "R1 R3 pending request held off", {req_ready, prog_bank}, 1);
        @(negedge clk);
        k++;
      end
    end
    check(done && done_ok, "R9 first job ok", {done, done_ok}, 3);
    check(!req_ready, "R1 ready low in done cycle", req_ready, 0);
    soft_exp++;
    check(soft_count == soft_exp[7:0], "R11 soft_count busy test", soft_count, soft_exp);
    @(negedge clk);
    check(req_ready, "R1 ready back in idle", req_ready, 1);
    clear_mon();
    cur_bank = 3'd6;
    @(negedge clk);
    check(repair_mode && prog_bank == 3'd6 && prog_row == 12'h321,
          "R1 pending request taken after idle", {prog_bank, prog_row}, {3'd6, 12'h321});
    req_valid = 1'b0;
    wait_done("pend");
    hard_exp++;
    check(done_ok && hard_count == hard_exp[7:0], "R11 hard_count after pending job",
          hard_count, hard_exp);
    check(fuse_n == PULSE_W && reload_n == RST_HOLD, "R5 pending hard job phases",
          fuse_n, PULSE_W);

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule